// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On a rising clock edge it captures a full external address and the three chip-enable inputs when an address strobe is active. Two strobes can start a burst. One comes from the processor and only counts while the pipelining enable is active. The other comes from the cache controller and always loads. A two-bit beat counter then produces the remaining three addresses of a four-beat burst. The counter moves forward only on edges where the advance input is asserted.

The burst order is chosen by the order input when the burst is loaded. With the order input high, the low two address bits follow an interleaved (XOR) order. With it low, they follow a linear order that wraps inside the aligned four-word block. The upper address bits come straight from the captured address. The address output is registered, so the first beat appears one cycle after the strobe edge. This gives the two-cycle first access, and every advance edge after that adds one beat per cycle (2-1-1-1).

Top module: `burst_addr_seq`

## Requirements
- R1: A controller strobe (`ctl_stb_n` low) at a rising edge loads `addr_in`. The captured address appears on `mem_addr` after that edge, and the beat counter restarts at zero.
- R2: At a load, `chip_sel` becomes `!sel_pipe_n && sel_hi && !sel_lo_n`. `burst_active` becomes equal to this value.
- R3: A processor strobe (`cpu_stb_n` low) loads exactly like R1 when `sel_pipe_n` is low. It is ignored when `sel_pipe_n` is high, and then `mem_addr` and `chip_sel` keep their values.
- R4: When no load happens, the counter steps by one only on edges where `adv_n` is low and `chip_sel` is high. On any other edge `mem_addr` is held.
- R5: With order bit 1 captured at the load, the low two bits of `mem_addr` are the start low bits XOR the counter (0,1,2,3).
- R6: With order bit 0 captured at the load, the low two bits are (start low bits + counter) mod 4.
- R7: `mem_addr[ADDR_W-1:2]` changes only on a load edge.
- R8: A load takes priority over an advance on the same edge. The new start address is used with the counter at zero.
- R9: The advance that follows the fourth beat wraps the counter to zero and returns the start address. `burst_active` falls at that edge while `chip_sel` stays high, and further advances keep stepping.
- R10: A synchronous reset (`rst` high) clears the counter, the captured address and the order bit, and drives `chip_sel` and `burst_active` low.
- R11: The order input is sampled only at a load. Changing it during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External start address |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_pipe_n | input | 1 | Pipelining chip enable, active low |
| sel_hi | input | 1 | Depth-expansion enable, active high |
| sel_lo_n | input | 1 | Depth-expansion enable, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| mem_addr | output | ADDR_W | Current burst address |
| burst_active | output | 1 | Selected burst with beats remaining |
| chip_sel | output | 1 | Registered chip select |

## Verification
The hardest case to reach from the ports is the wrap after the fourth beat. It needs four uninterrupted advance edges with no strobe of either kind in between, and this seldom happens under random strobes. Directed sequences drive exactly that run in both orders, starting from non-zero low bits. They also cover a strobe arriving on the same edge as an advance in the middle of a burst. The random phase keeps strobes rare so that long runs of advances also occur mixed with enable changes.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int unsigned BEAT_W = 2;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic              sel;
        order_e            order;
        logic              spent;
    } seq_state_t;

endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
    input  logic cpu_stb_n,
    input  logic ctl_stb_n,
    input  logic sel_pipe_n,
    input  logic sel_hi,
    input  logic sel_lo_n,
    output logic load,
    output logic sel_next
);
    logic cpu_take;
    logic ctl_take;

    always_comb begin
        // processor strobe only counts while the pipelining enable is active
        cpu_take = !cpu_stb_n && !sel_pipe_n;
        ctl_take = !ctl_stb_n;
        load     = cpu_take || ctl_take;
        sel_next = !sel_pipe_n && sel_hi && !sel_lo_n;
    end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
    import bsq_pkg::*;
#(
    parameter int unsigned LOW_W = BEAT_W
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] step,
    input  order_e           order,
    output logic [LOW_W-1:0] low
);
    logic [LOW_W-1:0] inter_low;
    logic [LOW_W-1:0] lin_low;

    always_comb begin
        inter_low = start ^ step;
        lin_low   = start + step;   // natural wrap modulo 2**LOW_W
        low       = (order == ORDER_INTERLEAVE) ? inter_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              sel_pipe_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              burst_active,
    output logic              chip_sel
);
    localparam int unsigned LOW_W = BEAT_W;
    localparam int unsigned HI_W  = ADDR_W - LOW_W;
    localparam logic [LOW_W-1:0] LAST_BEAT = {LOW_W{1'b1}};

    seq_state_t        st_d, st_q;
    logic [ADDR_W-1:0] base_d, base_q;
    logic              load;
    logic              sel_next;
    logic [LOW_W-1:0]  low_bits;

    bsq_strobe_decode u_dec (
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .sel_pipe_n(sel_pipe_n),
        .sel_hi    (sel_hi),
        .sel_lo_n  (sel_lo_n),
        .load      (load),
        .sel_next  (sel_next)
    );

    bsq_order_map #(.LOW_W(LOW_W)) u_map (
        .start(base_q[LOW_W-1:0]),
        .step (st_q.beat),
        .order(st_q.order),
        .low  (low_bits)
    );

    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        if (load) begin
            base_d   = addr_in;
            st_d.beat  = '0;
            st_d.sel   = sel_next;
            st_d.order = order_e'(order_sel);
            st_d.spent = 1'b0;
        end else if (!adv_n && st_q.sel) begin
            st_d.beat = st_q.beat + 1'b1;
            if (st_q.beat == LAST_BEAT) begin
                st_d.spent = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{beat: '0, sel: 1'b0, order: ORDER_LINEAR, spent: 1'b0};
            base_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
        end
    end

    logic [HI_W-1:0] hi_bits;
    assign hi_bits      = base_q[ADDR_W-1:LOW_W];
    assign mem_addr     = {hi_bits, low_bits};
    assign chip_sel     = st_q.sel;
    assign burst_active = st_q.sel && !st_q.spent;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int unsigned ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              adv_n,
    input logic              sel_pipe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              burst_active,
    input logic              chip_sel
);
    logic no_load;
    assign no_load = ctl_stb_n && (cpu_stb_n || sel_pipe_n);

    assert_ctl_load_R1: assert property (@(posedge clk) disable iff (rst)
        !ctl_stb_n |=> mem_addr == $past(addr_in));

    assert_active_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
        burst_active |-> chip_sel);

    assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stb_n && sel_pipe_n && ctl_stb_n && adv_n)
        |=> ($stable(mem_addr) && $stable(chip_sel)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (no_load && adv_n) |=> ($stable(mem_addr) && $stable(burst_active)));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        no_load |=> $stable(mem_addr[ADDR_W-1:2]));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!chip_sel && !burst_active && mem_addr == '0));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_in     (addr_in),
    .cpu_stb_n   (cpu_stb_n),
    .ctl_stb_n   (ctl_stb_n),
    .adv_n       (adv_n),
    .sel_pipe_n  (sel_pipe_n),
    .mem_addr    (mem_addr),
    .burst_active(burst_active),
    .chip_sel    (chip_sel)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int unsigned AW = 21;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          cpu_stb_n, ctl_stb_n, adv_n;
    logic          sel_pipe_n, sel_hi, sel_lo_n, order_sel;
    logic [AW-1:0] mem_addr;
    logic          burst_active, chip_sel;

    int total = 0;
    int bad   = 0;

    // expected-state model
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_sel = 1'b0, m_order = 1'b0, m_spent = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .sel_pipe_n(sel_pipe_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .order_sel(order_sel), .mem_addr(mem_addr),
        .burst_active(burst_active), .chip_sel(chip_sel)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic o);
        return o ? (s ^ b) : (s + b);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, m_order)};
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_base = '0; m_beat = '0; m_sel = 1'b0; m_order = 1'b0; m_spent = 1'b0;
        end else if (!ctl_stb_n || (!cpu_stb_n && !sel_pipe_n)) begin
            m_base  = addr_in;
            m_beat  = '0;
            m_sel   = !sel_pipe_n && sel_hi && !sel_lo_n;
            m_order = order_sel;
            m_spent = 1'b0;
        end else if (!adv_n && m_sel) begin
            if (m_beat == 2'd3) m_spent = 1'b1;
            m_beat = m_beat + 2'd1;
        end
    endtask

    task automatic check(string req);
        logic [AW-1:0] ea;
        logic eb, ec;
        ea = exp_addr();
        eb = m_sel && !m_spent;
        ec = m_sel;
        total++;
        if (mem_addr !== ea || burst_active !== eb || chip_sel !== ec) begin
            bad++;
            $display("FAIL %s: addr=%h act=%b cs=%b expected addr=%h act=%b cs=%b",
                     req, mem_addr, burst_active, chip_sel, ea, eb, ec);
        end
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req);
    endtask

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic sel_all();
        sel_pipe_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; addr_in = '0; order_sel = 1'b0;
        idle(); sel_all();
        @(negedge clk);
        step("R10");
        rst = 1'b0;

        // linear burst from low bits 2: 2,3,0,1 then wrap
        addr_in = 21'h0A5F2; order_sel = 1'b0; ctl_stb_n = 1'b0;
        step("R1");
        idle(); adv_n = 1'b0;
        step("R6"); step("R6"); step("R6");
        step("R9");                       // wrap to start, active drops
        step("R9");                       // keeps stepping after wrap
        adv_n = 1'b1;
        step("R4");

        // processor strobe, interleaved from low bits 3
        addr_in = 21'h1C3B7; order_sel = 1'b1; cpu_stb_n = 1'b0;
        step("R3");
        idle(); adv_n = 1'b0;
        order_sel = 1'b0;                 // changing order mid-burst has no effect
        step("R5"); step("R11"); step("R5");
        step("R9");

        // hold without advance
        addr_in = 21'h00011; ctl_stb_n = 1'b0; order_sel = 1'b1;
        step("R1");
        idle();
        step("R4"); step("R4");

        // strobe and advance on the same edge mid-burst
        adv_n = 1'b0; step("R4");
        addr_in = 21'h15556; ctl_stb_n = 1'b0; order_sel = 1'b0;
        step("R8");
        ctl_stb_n = 1'b1;
        step("R8");

        // processor strobe ignored with pipelining enable inactive
        adv_n = 1'b1; cpu_stb_n = 1'b0; sel_pipe_n = 1'b1; addr_in = 21'h0FFFF;
        step("R3");
        idle(); sel_all();

        // controller load with a depth enable off: deselected, advances ignored
        addr_in = 21'h12345; ctl_stb_n = 1'b0; sel_hi = 1'b0;
        step("R2");
        idle(); sel_all(); adv_n = 1'b0;
        step("R4");
        addr_in = 21'h02222; ctl_stb_n = 1'b0; sel_lo_n = 1'b1;
        step("R2");
        idle(); sel_all();

        // reset in the middle of a burst
        addr_in = 21'h0ABCD; ctl_stb_n = 1'b0;
        step("R1");
        idle(); adv_n = 1'b0; rst = 1'b1;
        step("R10");
        rst = 1'b0; adv_n = 1'b1;

        // constrained random phase
        void'($urandom(32'd20250611));
        for (int i = 0; i < 4000; i++) begin
            addr_in    = AW'($urandom);
            cpu_stb_n  = ($urandom_range(0, 9) != 0);
            ctl_stb_n  = ($urandom_range(0, 11) != 0);
            adv_n      = ($urandom_range(0, 9) < 3);
            sel_pipe_n = ($urandom_range(0, 7) == 0);
            sel_hi     = ($urandom_range(0, 7) != 0);
            sel_lo_n   = ($urandom_range(0, 7) == 0);
            order_sel  = $urandom_range(0, 1) == 1;
            rst        = ($urandom_range(0, 499) == 0);
            step("R7");
        end
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule